// File: doc/BRIEF.md
# Unaligned Access Splitter

This block sits between a processor's load/store unit and a system bus that accepts only naturally aligned transfers. It takes one memory request at a time. A request carries an address, a size (byte, halfword or word), a direction, up to 64 bits of store data and a flag that marks a double (two-word) transfer. The block issues the request as one or more aligned bus beats, one at a time. For loads it gathers the returned bytes into a single little-endian result.

A request that is already aligned goes straight to the bus as one beat in the same cycle, so it costs no extra latency. An unaligned single request is split by a greedy rule. At each step the block takes the widest aligned transfer (word, then halfword, then byte) that fits both the current address and the bytes still to send.

Beat addresses follow per-region rules. Requests that start in the lowest 512 MiB wrap inside that region. All other requests run on linearly, including across the top of the 32-bit space. Unaligned accesses to the private peripheral window, and doubles that are not word aligned, are refused with a fault and issue no beats.

Top module: `unaligned_splitter`

## Requirements
- R1: Every bus beat is naturally aligned: a word beat (size code 2) has address bits [1:0] = 0, and a halfword beat (size code 1) has bit 0 = 0. Beats go in increasing byte order, each the widest aligned size that fits. Half at offset 1 or 3 gives byte, byte. Word at offset 2 gives half, half. Word at offset 1 or 3 gives byte, half, byte.
- R2: A request that is aligned for its size (byte size code 0, or halfword or word on its natural boundary) is issued as one beat of that size. Its bus_valid is raised in the same cycle as req_valid, and resp_done is raised in the cycle that beat is accepted.
- R3: A double request (req_double = 1) ignores req_size. At a word-aligned address it becomes two word beats, at the address and at the next word, carrying req_wdata[31:0] first. At any other alignment it ends with resp_done = resp_fault = 1 in the request cycle and issues no beat.
- R4: When a request address has bits [31:29] = 0, every beat address keeps bits [31:29] = 0 and wraps within that region. For example, a halfword at 0x1FFFFFFF goes to 0x1FFFFFFF, then 0x00000000.
- R5: All other request addresses advance linearly modulo 2^32 with no special handling. A halfword at 0xDFFFFFFF goes to 0xDFFFFFFF, then 0xE0000000. A halfword at 0xFFFFFFFF goes to 0xFFFFFFFF, then 0x00000000. A halfword at 0x21FFFFFF goes to 0x21FFFFFF, then 0x22000000.
- R6: A single request to 0xE0000000..0xE00FFFFF (address bits [31:20] = 0xE00) that is not aligned for its size faults in the request cycle with no beat. Aligned requests there, and unaligned ones outside that window, are served normally.
- R7: On stores, each beat's byte j goes on bus lane (beat address[1:0] + j) and carries request byte (position + j), where position counts bytes already sent. Unused lanes are zero.
- R8: On loads, the byte read on lane (beat address[1:0] + j) is placed at resp_rdata byte (position + j). Bytes above the request size read zero when resp_done is high without a fault.
- R9: Only one beat is outstanding. A beat holds bus_valid, bus_addr and bus_size steady until bus_ready. The next beat follows in the cycle after acceptance. req_ready is high in the cycle the request is taken: the first beat is accepted, or a fault is reported.
- R10: A bus_err together with bus_ready on any beat ends the request in that cycle with resp_done = resp_fault = 1, and no further beats are issued.
- R11: While rst_n is low and afterwards until a request arrives, bus_valid and resp_done are 0. A reset in the middle of a request drops it, and the next request starts at its first beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until req_ready |
| req_ready | output | 1 | Request taken this cycle |
| req_addr | input | 32 | Byte address of the request |
| req_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| req_write | input | 1 | 1 store, 0 load |
| req_double | input | 1 | Two-word transfer |
| req_wdata | input | 64 | Store data, byte 0 at bits [7:0] |
| resp_done | output | 1 | Request finished this cycle |
| resp_fault | output | 1 | Request refused or bus error |
| resp_rdata | output | 64 | Assembled load data, valid with resp_done |
| bus_valid | output | 1 | Beat present |
| bus_ready | input | 1 | Beat accepted |
| bus_err | input | 1 | Error on the accepted beat |
| bus_addr | output | 32 | Aligned beat address |
| bus_size | output | 2 | Beat size code |
| bus_write | output | 1 | Beat direction |
| bus_wdata | output | 32 | Store lanes of the beat |
| bus_rdata | input | 32 | Load lanes of the beat |

## Verification
Beat k of a request appears at the ports in the same cycle it becomes current. The first beat shares the request cycle, and each later beat comes one cycle after the previous acceptance. With a bus that holds off s cycles per beat, beat k is therefore accepted in cycle k·(s+1)+s after the request is presented. resp_done must coincide with the last accepted beat, or with the request cycle itself for a refused request. The bench drives every input at the falling edge and samples outputs a fraction of a cycle later. At each sample it predicts which of those events is due from the stall count and the beat index. It compares address, size, lanes, done, fault and data in exactly that cycle, and also checks during stall cycles that the pending beat has not moved.

// File: rtl/usplit_pkg.sv
package usplit_pkg;
  localparam int BUS_BYTES = 4;
  localparam int REQ_BYTES = 8;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } size_e;

  function automatic logic [3:0] size_to_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    size_to_bytes = 4'd1;
      2'd1:    size_to_bytes = 4'd2;
      default: size_to_bytes = 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/usplit_check.sv
module usplit_check
  import usplit_pkg::*;
#(
  parameter int                 ADDR_W    = 32,
  parameter int                 PPB_TAG_W = 12,
  parameter logic [PPB_TAG_W-1:0] PPB_TAG = 12'hE00
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              dbl,
  output logic              fault,
  output logic [3:0]        total
);
  logic misalign;
  logic in_ppb;

  always_comb begin
    case (size)
      2'd0:    misalign = 1'b0;
      2'd1:    misalign = addr[0];
      default: misalign = |addr[1:0];
    endcase
    in_ppb = (addr[ADDR_W-1 -: PPB_TAG_W] == PPB_TAG);
    if (dbl) begin
      fault = |addr[1:0];
      total = 4'(REQ_BYTES);
    end else begin
      fault = misalign & in_ppb;
      total = size_to_bytes(size);
    end
  end
endmodule

// File: rtl/usplit_beat.sv
module usplit_beat
  import usplit_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int CODE_TAG_W = 3
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [3:0]        pos,
  input  logic [3:0]        total,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [1:0]        beat_size,
  output logic [3:0]        beat_bytes,
  output logic              beat_last
);
  localparam int LOW_W = ADDR_W - CODE_TAG_W;

  logic [3:0]        left;
  logic [1:0]        off;
  logic [ADDR_W-1:0] sum;
  logic              in_code;

  always_comb begin
    left    = total - pos;
    sum     = base + ADDR_W'(pos);
    off     = sum[1:0];
    in_code = (base[ADDR_W-1 -: CODE_TAG_W] == '0);
    if (left >= 4'd4 && off == 2'd0) begin
      beat_size = SZ_WORD;
    end else if (left >= 4'd2 && !off[0]) begin
      beat_size = SZ_HALF;
    end else begin
      beat_size = SZ_BYTE;
    end
    beat_bytes = size_to_bytes(beat_size);
    beat_last  = (pos + beat_bytes) >= total;
    beat_addr  = in_code ? {{CODE_TAG_W{1'b0}}, sum[LOW_W-1:0]} : sum;
  end
endmodule

// File: rtl/usplit_lanes.sv
module usplit_lanes
  import usplit_pkg::*;
(
  input  logic [8*REQ_BYTES-1:0] wdata,
  input  logic [3:0]             pos,
  input  logic [1:0]             lane_off,
  input  logic [3:0]             nbytes,
  input  logic [8*BUS_BYTES-1:0] rdata,
  output logic [8*BUS_BYTES-1:0] bus_wdata,
  output logic [8*REQ_BYTES-1:0] placed
);
  logic [1:0] lane;
  logic [2:0] src;

  always_comb begin
    bus_wdata = '0;
    placed    = '0;
    lane      = '0;
    src       = '0;
    for (int j = 0; j < BUS_BYTES; j++) begin
      lane = lane_off + 2'(j);
      src  = pos[2:0] + 3'(j);
      if (4'(j) < nbytes) begin
        bus_wdata[8*lane +: 8] = wdata[8*src +: 8];
        placed[8*src +: 8]     = rdata[8*lane +: 8];
      end
    end
  end
endmodule

// File: rtl/unaligned_splitter.sv
module unaligned_splitter
  import usplit_pkg::*;
#(
  parameter int                   ADDR_W     = 32,
  parameter int                   CODE_TAG_W = 3,
  parameter int                   PPB_TAG_W  = 12,
  parameter logic [PPB_TAG_W-1:0] PPB_TAG    = 12'hE00
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [1:0]             req_size,
  input  logic                   req_write,
  input  logic                   req_double,
  input  logic [8*REQ_BYTES-1:0] req_wdata,
  output logic                   resp_done,
  output logic                   resp_fault,
  output logic [8*REQ_BYTES-1:0] resp_rdata,
  output logic                   bus_valid,
  input  logic                   bus_ready,
  input  logic                   bus_err,
  output logic [ADDR_W-1:0]      bus_addr,
  output logic [1:0]             bus_size,
  output logic                   bus_write,
  output logic [8*BUS_BYTES-1:0] bus_wdata,
  input  logic [8*BUS_BYTES-1:0] bus_rdata
);
  localparam int RW = 8 * REQ_BYTES;

  // registered request context, loaded when a multi-beat request starts
  logic              busy_q,  busy_d;
  logic [ADDR_W-1:0] base_q,  base_d;
  logic [3:0]        total_q, total_d;
  logic [3:0]        pos_q,   pos_d;
  logic [RW-1:0]     wdata_q, wdata_d;
  logic              write_q, write_d;
  logic [RW-1:0]     acc_q,   acc_d;

  logic              chk_fault;
  logic [3:0]        chk_total;
  logic [ADDR_W-1:0] sel_base;
  logic [3:0]        sel_total, sel_pos;
  logic [RW-1:0]     sel_wdata, sel_acc, placed;
  logic              sel_write;
  logic [ADDR_W-1:0] beat_addr;
  logic [1:0]        beat_size;
  logic [3:0]        beat_bytes;
  logic              beat_last;
  logic              refuse, xfer, finish, advance;

  usplit_check #(
    .ADDR_W(ADDR_W), .PPB_TAG_W(PPB_TAG_W), .PPB_TAG(PPB_TAG)
  ) u_check (
    .addr(req_addr), .size(req_size), .dbl(req_double),
    .fault(chk_fault), .total(chk_total)
  );

  always_comb begin
    sel_base  = busy_q ? base_q  : req_addr;
    sel_total = busy_q ? total_q : chk_total;
    sel_pos   = busy_q ? pos_q   : 4'd0;
    sel_wdata = busy_q ? wdata_q : req_wdata;
    sel_write = busy_q ? write_q : req_write;
    sel_acc   = busy_q ? acc_q   : '0;
  end

  usplit_beat #(
    .ADDR_W(ADDR_W), .CODE_TAG_W(CODE_TAG_W)
  ) u_beat (
    .base(sel_base), .pos(sel_pos), .total(sel_total),
    .beat_addr(beat_addr), .beat_size(beat_size),
    .beat_bytes(beat_bytes), .beat_last(beat_last)
  );

  usplit_lanes u_lanes (
    .wdata(sel_wdata), .pos(sel_pos), .lane_off(beat_addr[1:0]),
    .nbytes(beat_bytes), .rdata(bus_rdata),
    .bus_wdata(bus_wdata), .placed(placed)
  );

  // handshake and response
  always_comb begin
    refuse     = ~busy_q & req_valid & chk_fault;
    bus_valid  = busy_q | (req_valid & ~chk_fault);
    bus_addr   = beat_addr;
    bus_size   = beat_size;
    bus_write  = sel_write;
    xfer       = bus_valid & bus_ready;
    finish     = xfer & (bus_err | beat_last);
    advance    = xfer & ~bus_err & ~beat_last;
    req_ready  = ~busy_q & (chk_fault | bus_ready);
    resp_done  = refuse | finish;
    resp_fault = refuse | (xfer & bus_err);
    resp_rdata = sel_acc | placed;
  end

  // next state
  always_comb begin
    busy_d  = busy_q;
    base_d  = base_q;
    total_d = total_q;
    pos_d   = pos_q;
    wdata_d = wdata_q;
    write_d = write_q;
    acc_d   = acc_q;
    if (finish) begin
      busy_d = 1'b0;
    end else if (advance) begin
      busy_d = 1'b1;
      pos_d  = sel_pos + beat_bytes;
      acc_d  = sel_acc | placed;
      if (!busy_q) begin
        base_d  = req_addr;
        total_d = chk_total;
        wdata_d = req_wdata;
        write_d = req_write;
      end
    end
  end

  // registers: control with reset, datapath with clock enable only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pos_q  <= 4'd0;
    end else begin
      busy_q <= busy_d;
      pos_q  <= pos_d;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      base_q  <= base_d;
      total_q <= total_d;
      wdata_q <= wdata_d;
      write_q <= write_d;
      acc_q   <= acc_d;
    end
  end

  // assertions
  assert_beat_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ((bus_size == SZ_BYTE) ||
                   (bus_size == SZ_HALF && !bus_addr[0]) ||
                   (bus_size == SZ_WORD && bus_addr[1:0] == 2'd0)));

  assert_refuse_no_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy_q && chk_fault) |-> (!bus_valid && resp_done && resp_fault));

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_size)));

  assert_err_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && bus_err) |=> !busy_q);

  assert_code_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && base_q[ADDR_W-1 -: CODE_TAG_W] == '0) |-> (bus_addr[ADDR_W-1 -: CODE_TAG_W] == '0));

  assert_fault_has_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> resp_done);
endmodule

// File: tb/unaligned_splitter_bench.sv
`timescale 1ns/100ps
module unaligned_splitter_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write, req_double;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic [63:0] req_wdata;
  logic        resp_done, resp_fault;
  logic [63:0] resp_rdata;
  logic        bus_valid, bus_ready, bus_err, bus_write;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  bus_size;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  unaligned_splitter u_unaligned_splitter (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_double(req_double),
    .req_wdata(req_wdata), .resp_done(resp_done), .resp_fault(resp_fault),
    .resp_rdata(resp_rdata), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_err(bus_err), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // byte content of the modelled memory at an address
  function automatic logic [7:0] memb(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[31:24] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] word_at(input logic [31:0] a);
    logic [31:0] w;
    for (int j = 0; j < 4; j++) w[8*j +: 8] = memb({a[31:2], 2'(j)});
    return w;
  endfunction

  // address of request byte i per R4 and R5
  function automatic logic [31:0] eff(input logic [31:0] a, input int i);
    logic [31:0] s;
    s = a + 32'(i);
    if (a[31:29] == 3'd0) s[31:29] = 3'd0;
    return s;
  endfunction

  task automatic run_req(input logic [31:0] a, input logic [1:0] sz,
                         input logic dbl, input logic wr, input logic [63:0] wd,
                         input int nb, input logic [5:0] bs, input bit flt,
                         input int stall, input int errb, input int tag);
    int   beat = 0;
    int   pos = 0;
    int   cyc = 0;
    int   waitc = 0;
    int   nbytes;
    bit   taken = 0;
    bit   fin = 0;
    logic [63:0] exp_rd = '0;
    logic [31:0] exp_wd;
    logic [31:0] ba;
    int   bb;
    string rq;
    rq = $sformatf("R%0d", tag);
    nbytes = dbl ? 8 : (sz == 2'd0 ? 1 : (sz == 2'd1 ? 2 : 4));
    for (int i = 0; i < nbytes; i++) exp_rd[8*i +: 8] = memb(eff(a, i));
    @(negedge clk);
    req_addr = a; req_size = sz; req_double = dbl; req_write = wr;
    req_wdata = wd; req_valid = 1'b1;
    while (!fin && cyc < 60) begin
      bus_ready = (waitc >= stall);
      bus_err   = bus_ready && (beat == errb);
      #0.5;
      bus_rdata = word_at(bus_addr);
      #0.5;
      if (bus_valid && !bus_ready) begin
        check(bus_addr == eff(a, pos), "R9", "stalled beat address", {32'd0, bus_addr}, {32'd0, eff(a, pos)});
      end
      if (bus_valid && bus_ready) begin
        check(beat < nb, rq, "unexpected beat", 64'(beat), 64'(nb));
        ba = eff(a, pos);
        bb = (bs[2*beat +: 2] == 2'd0) ? 1 : (bs[2*beat +: 2] == 2'd1 ? 2 : 4);
        check(bus_addr == ba, rq, "beat address", {32'd0, bus_addr}, {32'd0, ba});
        check(bus_size == bs[2*beat +: 2], rq, "beat size", 64'(bus_size), 64'(bs[2*beat +: 2]));
        check(cyc == beat * (stall + 1) + stall, "R9", "beat cycle", 64'(cyc), 64'(beat * (stall + 1) + stall));
        check(resp_done == (beat == nb - 1 || beat == errb), rq, "done with beat", 64'(resp_done), 64'(beat == nb - 1 || beat == errb));
        if (wr) begin
          exp_wd = '0;
          for (int j = 0; j < bb; j++) exp_wd[8*(32'(ba[1:0]) + j) +: 8] = wd[8*(pos + j) +: 8];
          check(bus_wdata == exp_wd, "R7", "store lanes", {32'd0, bus_wdata}, {32'd0, exp_wd});
        end
        pos += bb;
        beat++;
        waitc = 0;
      end else begin
        waitc++;
      end
      if (resp_done) begin
        check(resp_fault == (flt || errb < nb), rq, "fault", 64'(resp_fault), 64'(flt || errb < nb));
        if (flt) check(cyc == 0 && beat == 0, rq, "refused in request cycle", 64'(cyc), 64'd0);
        if (!wr && !flt && errb >= nb)
          check(resp_rdata == exp_rd, "R8", "load data", resp_rdata, exp_rd);
        fin = 1;
      end
      if (req_valid && req_ready) taken = 1;
      cyc++;
      @(negedge clk);
      if (taken) req_valid = 1'b0;
    end
    check(fin, rq, "request completed", 64'(fin), 64'd1);
    bus_ready = 1'b0;
    bus_err = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] a;
    logic [1:0]  sz;
    logic        dbl;
    logic [1:0]  nb;
    logic        flt;
    logic [5:0]  bs;   // beat k size in bits [2k+1:2k]: 0 byte, 1 half, 2 word
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 2'd2, 1'b0, 2'd1, 1'b0, 6'b000010, 4'd2},  // R2 aligned word
    '{32'h0000_1001, 2'd1, 1'b0, 2'd2, 1'b0, 6'b000000, 4'd1},  // R1 half off 1
    '{32'h0000_1003, 2'd1, 1'b0, 2'd2, 1'b0, 6'b000000, 4'd1},  // R1 half off 3
    '{32'h0000_1002, 2'd2, 1'b0, 2'd2, 1'b0, 6'b000101, 4'd1},  // R1 word off 2
    '{32'h0000_1001, 2'd2, 1'b0, 2'd3, 1'b0, 6'b000100, 4'd1},  // R1 word off 1
    '{32'h0000_1003, 2'd2, 1'b0, 2'd3, 1'b0, 6'b000100, 4'd1},  // R1 word off 3
    '{32'h1FFF_FFFF, 2'd1, 1'b0, 2'd2, 1'b0, 6'b000000, 4'd4},  // R4 wrap half
    '{32'h1FFF_FFFD, 2'd2, 1'b0, 2'd3, 1'b0, 6'b000100, 4'd4},  // R4 wrap word
    '{32'hDFFF_FFFF, 2'd1, 1'b0, 2'd2, 1'b0, 6'b000000, 4'd5},  // R5 linear
    '{32'hFFFF_FFFF, 2'd1, 1'b0, 2'd2, 1'b0, 6'b000000, 4'd5},  // R5 rollover
    '{32'h21FF_FFFF, 2'd1, 1'b0, 2'd2, 1'b0, 6'b000000, 4'd5},  // R5 alias plain
    '{32'hE000_0001, 2'd1, 1'b0, 2'd0, 1'b1, 6'b000000, 4'd6},  // R6 refused
    '{32'hE00F_FFFE, 2'd2, 1'b0, 2'd0, 1'b1, 6'b000000, 4'd6},  // R6 refused
    '{32'hE000_0004, 2'd2, 1'b0, 2'd1, 1'b0, 6'b000010, 4'd6},  // R6 aligned ok
    '{32'hE010_0001, 2'd1, 1'b0, 2'd2, 1'b0, 6'b000000, 4'd6},  // R6 outside window
    '{32'h0000_2000, 2'd0, 1'b1, 2'd2, 1'b0, 6'b001010, 4'd3},  // R3 double
    '{32'h0000_2002, 2'd2, 1'b1, 2'd0, 1'b1, 6'b000000, 4'd3},  // R3 misaligned double
    '{32'h1FFF_FFFC, 2'd2, 1'b1, 2'd2, 1'b0, 6'b001010, 4'd3},  // R3 double with R4 wrap
    '{32'h4000_0006, 2'd1, 1'b0, 2'd1, 1'b0, 6'b000001, 4'd2},  // R2 aligned half
    '{32'h4000_0003, 2'd0, 1'b0, 2'd1, 1'b0, 6'b000000, 4'd2}   // R2 byte
  };

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0;
    req_write = 1'b0; req_double = 1'b0; req_wdata = '0;
    bus_ready = 1'b0; bus_err = 1'b0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    // R11: quiet during reset
    check(!bus_valid && !resp_done, "R11", "quiet in reset", {62'd0, bus_valid, resp_done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!bus_valid && !resp_done, "R11", "quiet after reset", {62'd0, bus_valid, resp_done}, 64'd0);

    // table walk: loads and stores, several stall depths
    for (int v = 0; v < NV; v++) begin
      for (int w = 0; w < 2; w++) begin
        run_req(VECS[v].a, VECS[v].sz, VECS[v].dbl, 1'(w),
                {VECS[v].a ^ 32'h1357_9BDF, ~VECS[v].a} + 64'(v),
                int'(VECS[v].nb), VECS[v].bs, VECS[v].flt,
                (v + w) % 3, 99, int'(VECS[v].tag));
      end
    end

    // R10: bus error on the second beat of a three-beat store, and on a single load
    run_req(32'h0000_3001, 2'd2, 1'b0, 1'b1, 64'h0123_4567_89AB_CDEF, 3, 6'b000100, 1'b0, 1, 1, 10);
    run_req(32'h0000_3004, 2'd2, 1'b0, 1'b0, 64'd0, 1, 6'b000010, 1'b0, 0, 0, 10);

    // R11: reset in the middle of a split request, then a fresh request
    @(negedge clk);
    req_addr = 32'h0000_5001; req_size = 2'd2; req_double = 1'b0;
    req_write = 1'b0; req_valid = 1'b1; bus_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; bus_ready = 1'b0;
    #1;
    check(bus_valid && bus_addr == 32'h0000_5002, "R11", "second beat pending", {32'd0, bus_addr}, 64'h5002);
    rst_n = 1'b0;
    #1;
    check(!bus_valid, "R11", "reset drops beat", 64'(bus_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    run_req(32'h0000_6003, 2'd1, 1'b0, 1'b0, 64'd0, 2, 6'b000000, 1'b0, 0, 99, 11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule